// File: doc/BRIEF.md
# Supply Fault and Reset Supervisor

This block turns raw per-conversion limit flags into the three board-level supervision outputs of a power-supply manager. Every monitored channel delivers an undervoltage and an overvoltage flag with each conversion, marked by a one-cycle conversion strobe, and the two device supplies deliver a lockout flag each. Each flag is qualified by a programmable count of back-to-back agreeing conversions before the block accepts a change of state, so a single noisy conversion neither raises nor clears a fault.

Five routing masks, one bit per qualified source, choose which sources drive the health output, the latched interrupt, the reset output, a forced-shutdown request and a power-off request. The health output follows its sources and recovers by itself; the interrupt latches until a clear input releases it; the reset output is held from reset and releases only after a selectable hold-off once its sources are clear and manual reset is inactive. Each of the three outputs has its own polarity bit. A power-down indication from the sequencer drops the health output ahead of anything else. The converter, thresholds and sequencer lie outside the block.

Top module: `supv_fault_rst`

## Requirements
- R1: A qualified source changes state only on a conversion strobe, and only after `need_i` consecutive strobes whose raw flag differs from the qualified state; a strobe whose raw flag equals the qualified state restarts the count, cycles without a strobe do not count, and `need_i` = 0 behaves as 1.
- R2: The internal health state is active when no qualified source enabled in `mask_hlt_i` is in fault and no power-down is indicated; it goes inactive on the clock after such a source qualifies as in fault and returns by itself on the clock after all clear.
- R3: While `pwr_down_i` is high the health state is inactive from the next clock on, whatever the sources.
- R4: The reset state is active from reset; any qualified fault enabled in `mask_rst_i`, or `man_rst_i` high, makes it active on the next clock; it becomes inactive only after that reset source set has stayed clear for the selected hold-off.
- R5: The hold-off is `HOLD_T0`, `HOLD_T1`, `HOLD_T2` or `HOLD_T3` clock cycles for `hold_sel_i` = 0, 1, 2, 3 (defaults 2, 150, 300, 600, a scaled 0.64 : 50 : 100 : 200 ms ratio).
- R6: The interrupt state is set on the clock after a qualified fault enabled in `mask_irq_i` is present, stays set after the fault clears, and is cleared by `irq_clr_i` only on a clock where no enabled fault is present; when set and clear meet in one cycle, set wins.
- R7: Each output pin carries its state active-high when its polarity bit (`pol_hlt_i`, `pol_irq_i`, `pol_rst_i`) is 1 and active-low when it is 0.
- R8: Source bit i of every mask is channel i undervoltage for i < NCH, channel i-NCH overvoltage for NCH <= i < 2*NCH, device supply lockout at 2*NCH and control supply lockout at 2*NCH+1; each mask acts on its own destination only.
- R9: `fs_req_o` and `off_req_o` are high on the clock after a qualified fault enabled in `mask_fs_i` or `mask_off_i`, respectively, is present, and low otherwise.
- R10: During reset the health and interrupt states are inactive, the reset state is active, and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_stb_i | input | 1 | One-cycle marker of a new conversion result |
| uv_raw_i | input | NCH | Raw undervoltage flag per channel |
| ov_raw_i | input | NCH | Raw overvoltage flag per channel |
| vdd_low_i | input | 1 | Raw device supply lockout flag |
| ctl_low_i | input | 1 | Raw control supply lockout flag |
| man_rst_i | input | 1 | Manual reset, active high |
| irq_clr_i | input | 1 | Interrupt clear request |
| pwr_down_i | input | 1 | Power-down sequence in progress |
| need_i | input | DB_W | Consecutive conversions needed to change state |
| hold_sel_i | input | 2 | Reset hold-off selection |
| mask_hlt_i | input | 2*NCH+2 | Sources routed to health |
| mask_irq_i | input | 2*NCH+2 | Sources routed to interrupt |
| mask_rst_i | input | 2*NCH+2 | Sources routed to reset |
| mask_fs_i | input | 2*NCH+2 | Sources routed to forced-shutdown request |
| mask_off_i | input | 2*NCH+2 | Sources routed to power-off request |
| pol_hlt_i | input | 1 | Health pin polarity, 1 = active high |
| pol_irq_i | input | 1 | Interrupt pin polarity, 1 = active high |
| pol_rst_i | input | 1 | Reset pin polarity, 1 = active high |
| healthy_o | output | 1 | Health pin |
| irq_o | output | 1 | Latched interrupt pin |
| rst_o | output | 1 | Reset pin |
| fs_req_o | output | 1 | Forced-shutdown request to the sequencer |
| off_req_o | output | 1 | Power-off request to the sequencer |

## Verification
The interrupt latch has two functions that can land on the same clock: a newly qualified fault setting it and a clear request releasing it. The bench holds the clear input high across the strobe on which a fault completes its qualification count and expects the interrupt to end up set, and it also holds clear high while a fault stays present and expects nothing to change until the fault has qualified clear. A cycle-by-cycle behavioural model running beside the design judges every output on every clock, so the outcome of each such collision is compared in the exact cycle it occurs.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        HOLD_S0 = 2'd0,
        HOLD_S1 = 2'd1,
        HOLD_S2 = 2'd2,
        HOLD_S3 = 2'd3
    } hold_sel_e;

    // Maps an internal active state onto a pin of the chosen polarity.
    function automatic logic pin_drive(input logic act, input logic pol);
        return pol ? act : !act;
    endfunction

endpackage

// File: rtl/supv_qualifier.sv
module supv_qualifier #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          stb_i,
    input  logic          raw_i,
    input  logic [CW-1:0] need_i,
    output logic          qual_o
);

    typedef struct packed {
        logic          qual;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = (need_i == '0) ? CW'(1) : need_i;
        if (stb_i) begin
            if (raw_i == st_q.qual) begin
                st_d.cnt = '0;
            end else if (({1'b0, st_q.cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, lim}) begin
                st_d.qual = raw_i;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign qual_o = st_q.qual;

    // R1: no strobe, no change of the qualified state
    assert_change_on_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stb_i |=> $stable(st_q.qual));

endmodule

// File: rtl/supv_rst_timer.sv
module supv_rst_timer import supv_pkg::*; #(
    parameter int T0 = 2,
    parameter int T1 = 150,
    parameter int T2 = 300,
    parameter int T3 = 600
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      src_i,
    input  hold_sel_e sel_i,
    output logic      act_o
);

    localparam int TM01 = (T0 > T1) ? T0 : T1;
    localparam int TM23 = (T2 > T3) ? T2 : T3;
    localparam int TMAX = (TM01 > TM23) ? TM01 : TM23;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        logic          act;
        logic [TW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [TW-1:0] last;

    always_comb begin
        case (sel_i)
            HOLD_S0: last = TW'(T0 - 1);
            HOLD_S1: last = TW'(T1 - 1);
            HOLD_S2: last = TW'(T2 - 1);
            default: last = TW'(T3 - 1);
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (src_i) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.act) begin
            if (st_q.cnt >= last) st_d.act = 1'b0;
            else                  st_d.cnt = st_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{act: 1'b1, cnt: '0};
        else         st_q <= st_d;
    end

    assign act_o = st_q.act;

    // R4: a present reset source holds reset on the following clock
    assert_src_holds_rst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_i |=> st_q.act);

    // R4: release happens only from a cleared source set
    assert_release_needs_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.act && src_i) |=> st_q.act);

endmodule

// File: rtl/supv_irq_latch.sv
module supv_irq_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_i,
    input  logic clr_i,
    output logic irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (src_i)      irq_d = 1'b1;
        else if (clr_i) irq_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R6: an enabled fault sets the latch, even against a clear
    assert_fault_sets_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_i |=> irq_q);

    // R6: without a clear the latch keeps its set state
    assert_irq_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_q && !clr_i) |=> irq_q);

endmodule

// File: rtl/supv_fault_rst.sv
module supv_fault_rst import supv_pkg::*; #(
    parameter int NCH     = 4,
    parameter int DB_W    = 4,
    parameter int HOLD_T0 = 2,
    parameter int HOLD_T1 = 150,
    parameter int HOLD_T2 = 300,
    parameter int HOLD_T3 = 600,
    localparam int NSRC   = 2 * NCH + 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            conv_stb_i,
    input  logic [NCH-1:0]  uv_raw_i,
    input  logic [NCH-1:0]  ov_raw_i,
    input  logic            vdd_low_i,
    input  logic            ctl_low_i,
    input  logic            man_rst_i,
    input  logic            irq_clr_i,
    input  logic            pwr_down_i,
    input  logic [DB_W-1:0] need_i,
    input  logic [1:0]      hold_sel_i,
    input  logic [NSRC-1:0] mask_hlt_i,
    input  logic [NSRC-1:0] mask_irq_i,
    input  logic [NSRC-1:0] mask_rst_i,
    input  logic [NSRC-1:0] mask_fs_i,
    input  logic [NSRC-1:0] mask_off_i,
    input  logic            pol_hlt_i,
    input  logic            pol_irq_i,
    input  logic            pol_rst_i,
    output logic            healthy_o,
    output logic            irq_o,
    output logic            rst_o,
    output logic            fs_req_o,
    output logic            off_req_o
);

    typedef struct packed {
        logic hlt;
        logic fs;
        logic off;
    } outs_t;

    logic [NSRC-1:0] src_raw;
    logic [NSRC-1:0] qual;
    logic            flt_hlt, flt_irq, flt_rst, flt_fs, flt_off;
    logic            rst_src, irq_act, rst_act;
    outs_t           o_d, o_q;

    // source order: UV channels, OV channels, device lockout, control lockout
    assign src_raw = {ctl_low_i, vdd_low_i, ov_raw_i, uv_raw_i};

    for (genvar g = 0; g < NSRC; g++) begin : g_qual
        supv_qualifier #(.CW(DB_W)) u_qual (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .stb_i  (conv_stb_i),
            .raw_i  (src_raw[g]),
            .need_i (need_i),
            .qual_o (qual[g])
        );
    end

    assign flt_hlt = |(qual & mask_hlt_i);
    assign flt_irq = |(qual & mask_irq_i);
    assign flt_rst = |(qual & mask_rst_i);
    assign flt_fs  = |(qual & mask_fs_i);
    assign flt_off = |(qual & mask_off_i);
    assign rst_src = flt_rst || man_rst_i;

    always_comb begin
        o_d     = o_q;
        o_d.hlt = !pwr_down_i && !flt_hlt;
        o_d.fs  = flt_fs;
        o_d.off = flt_off;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) o_q <= '0;
        else         o_q <= o_d;
    end

    supv_irq_latch u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (flt_irq),
        .clr_i  (irq_clr_i),
        .irq_o  (irq_act)
    );

    supv_rst_timer #(
        .T0 (HOLD_T0),
        .T1 (HOLD_T1),
        .T2 (HOLD_T2),
        .T3 (HOLD_T3)
    ) u_rst (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (rst_src),
        .sel_i  (hold_sel_e'(hold_sel_i)),
        .act_o  (rst_act)
    );

    assign healthy_o = pin_drive(o_q.hlt, pol_hlt_i);
    assign irq_o     = pin_drive(irq_act, pol_irq_i);
    assign rst_o     = pin_drive(rst_act, pol_rst_i);
    assign fs_req_o  = o_q.fs;
    assign off_req_o = o_q.off;

    // R3: power-down drops health on the next clock
    assert_pwrdown_drops_hlt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_down_i |=> !o_q.hlt);

    // R2: a routed qualified fault drops health on the next clock
    assert_fault_drops_hlt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_hlt |=> !o_q.hlt);

    // R9: shutdown request follows its routed faults one clock later
    assert_fs_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_fs |=> fs_req_o);

    // R9: power-off request is low one clock after its routed faults clear
    assert_off_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flt_off |=> !off_req_o);

endmodule

// File: tb/supv_fault_rst_tb_top.sv
module supv_fault_rst_tb_top;

    localparam int NCH  = 4;
    localparam int DB_W = 4;
    localparam int NSRC = 2 * NCH + 2;
    localparam int TH0 = 2, TH1 = 150, TH2 = 300, TH3 = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            conv_stb = 0;
    logic [NCH-1:0]  uv_raw = '0, ov_raw = '0;
    logic            vdd_low = 0, ctl_low = 0, man_rst = 0, irq_clr = 0, pwr_down = 0;
    logic [DB_W-1:0] need = 4'd3;
    logic [1:0]      hold_sel = 2'd0;
    logic [NSRC-1:0] m_hlt = '1;
    logic [NSRC-1:0] m_irq = NSRC'(1);                       // UV ch0 only
    logic [NSRC-1:0] m_rst = NSRC'((1 << NCH) - 1);          // all UV
    logic [NSRC-1:0] m_fs  = NSRC'(((1 << NCH) - 1) << NCH); // all OV
    logic [NSRC-1:0] m_off = NSRC'(3 << (2 * NCH));          // both lockouts
    logic            p_hlt = 1, p_irq = 0, p_rst = 0;
    logic            healthy, irq, rst, fs_req, off_req;

    supv_fault_rst #(.NCH(NCH), .DB_W(DB_W), .HOLD_T0(TH0), .HOLD_T1(TH1),
                     .HOLD_T2(TH2), .HOLD_T3(TH3)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .conv_stb_i(conv_stb), .uv_raw_i(uv_raw),
        .ov_raw_i(ov_raw), .vdd_low_i(vdd_low), .ctl_low_i(ctl_low),
        .man_rst_i(man_rst), .irq_clr_i(irq_clr), .pwr_down_i(pwr_down),
        .need_i(need), .hold_sel_i(hold_sel), .mask_hlt_i(m_hlt),
        .mask_irq_i(m_irq), .mask_rst_i(m_rst), .mask_fs_i(m_fs),
        .mask_off_i(m_off), .pol_hlt_i(p_hlt), .pol_irq_i(p_irq),
        .pol_rst_i(p_rst), .healthy_o(healthy), .irq_o(irq), .rst_o(rst),
        .fs_req_o(fs_req), .off_req_o(off_req));

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mq[NSRC]   = '{default: 0};
    int mcnt[NSRC] = '{default: 0};
    bit m_h = 0, m_i = 0, m_r = 1, m_f = 0, m_o = 0;
    int m_tc = 0;

    function automatic int hold_len(input logic [1:0] s);
        case (s)
            2'd0: return TH0;
            2'd1: return TH1;
            2'd2: return TH2;
            default: return TH3;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (mq[i]) begin mq[i] = 0; mcnt[i] = 0; end
            m_h = 0; m_i = 0; m_r = 1; m_f = 0; m_o = 0; m_tc = 0;
        end else begin
            bit ah, ai, ar, af, ao;
            logic [NSRC-1:0] raw;
            int lim;
            ah = 0; ai = 0; ar = 0; af = 0; ao = 0;
            for (int i = 0; i < NSRC; i++) if (mq[i] != 0) begin
                ah |= m_hlt[i]; ai |= m_irq[i]; ar |= m_rst[i];
                af |= m_fs[i];  ao |= m_off[i];
            end
            m_h = !pwr_down && !ah;
            m_f = af;
            m_o = ao;
            if (ai) m_i = 1; else if (irq_clr) m_i = 0;
            if (ar || man_rst) begin
                m_r = 1; m_tc = 0;
            end else if (m_r) begin
                if (m_tc + 1 >= hold_len(hold_sel)) m_r = 0;
                else m_tc++;
            end
            raw = {ctl_low, vdd_low, ov_raw, uv_raw};
            lim = (need == 0) ? 1 : int'(need);
            if (conv_stb) for (int i = 0; i < NSRC; i++) begin
                if (int'(raw[i]) == mq[i]) mcnt[i] = 0;
                else if (mcnt[i] + 1 >= lim) begin mq[i] = int'(raw[i]); mcnt[i] = 0; end
                else mcnt[i]++;
            end
        end
    end

    function automatic logic pin(input bit a, input logic p);
        return p ? logic'(a) : logic'(!a);
    endfunction

    bit cmp_on = 0;
    always @(negedge clk) if (cmp_on) begin
        chk("R2/R3/R7 healthy vs model", healthy, pin(m_h, p_hlt));
        chk("R6/R7 irq vs model",        irq,     pin(m_i, p_irq));
        chk("R4/R5/R7 rst vs model",     rst,     pin(m_r, p_rst));
        chk("R9 fs_req vs model",        fs_req,  logic'(m_f));
        chk("R9 off_req vs model",       off_req, logic'(m_o));
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) @(negedge clk);
    endtask

    task automatic strobe(input int k);
        for (int j = 0; j < k; j++) begin
            conv_stb = 1; @(negedge clk);
            conv_stb = 0; @(negedge clk);
        end
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        @(negedge clk);
        cmp_on = 1;
        chk("R10 reset healthy inactive", healthy, 1'b0);
        chk("R10 reset irq inactive",     irq,     1'b1);
        chk("R10 reset rst active",       rst,     1'b0);
        chk("R10 reset fs_req low",       fs_req,  1'b0);
        chk("R10 reset off_req low",      off_req, 1'b0);
        idle(2);
        rst_n = 1;
        idle(5);
        chk("R4 rst released after hold-off", rst, 1'b1);
        chk("R2 healthy active when clean",   healthy, 1'b1);

        // R1: two agreeing strobes are not enough; a matching one restarts
        uv_raw[0] = 1; strobe(2);
        chk("R1 two strobes do not qualify", healthy, 1'b1);
        uv_raw[0] = 0; strobe(1);
        uv_raw[0] = 1; strobe(2);
        chk("R1 count restarted by match", healthy, 1'b1);
        idle(3);
        chk("R1 idle cycles do not count", healthy, 1'b1);
        strobe(1);
        chk("R2 healthy drops on fault", healthy, 1'b0);
        chk("R6 irq set on fault",       irq,     1'b0);
        chk("R4 rst asserts on fault",   rst,     1'b0);

        uv_raw[0] = 0; strobe(3); idle(4);
        chk("R2 healthy recovers",     healthy, 1'b1);
        chk("R6 irq stays latched",    irq,     1'b0);
        chk("R4 rst released again",   rst,     1'b1);
        irq_clr = 1; @(negedge clk); irq_clr = 0; idle(1);
        chk("R6 clear releases irq",   irq,     1'b1);

        // R6: clear held while the source is present is ignored
        uv_raw[0] = 1; strobe(3);
        irq_clr = 1; idle(3);
        chk("R6 clear ignored while active", irq, 1'b0);
        uv_raw[0] = 0; strobe(3); idle(1);
        chk("R6 clear takes effect once clean", irq, 1'b1);
        irq_clr = 0; idle(4);

        // R8/R9: OV ch2 routes to shutdown request only
        ov_raw[2] = 1; strobe(3);
        chk("R9 fs_req from OV",          fs_req,  1'b1);
        chk("R8 off_req untouched by OV", off_req, 1'b0);
        chk("R8 irq untouched by OV",     irq,     1'b1);
        chk("R8 rst untouched by OV",     rst,     1'b1);
        chk("R8 healthy sees OV",         healthy, 1'b0);
        ov_raw[2] = 0; strobe(3);
        chk("R9 fs_req clears", fs_req, 1'b0);

        // R8/R9: device lockout routes to power-off request
        vdd_low = 1; strobe(3);
        chk("R9 off_req from lockout",         off_req, 1'b1);
        chk("R8 fs_req untouched by lockout",  fs_req,  1'b0);
        vdd_low = 0; strobe(3);
        chk("R9 off_req clears", off_req, 1'b0);

        // R3: power-down drops health with all sources clean
        pwr_down = 1; idle(2);
        chk("R3 healthy off in power-down", healthy, 1'b0);
        pwr_down = 0; idle(2);
        chk("R3 healthy back after power-down", healthy, 1'b1);

        // R4/R5: manual reset with the second hold-off
        hold_sel = 2'd1;
        man_rst = 1; idle(2);
        chk("R4 manual reset asserts rst", rst, 1'b0);
        man_rst = 0; idle(100);
        chk("R5 still held before hold-off", rst, 1'b0);
        idle(60);
        chk("R5 released after hold-off", rst, 1'b1);
        hold_sel = 2'd0;

        // R6: set and clear in the same cycle, set wins
        uv_raw[0] = 1; strobe(2);
        irq_clr = 1; strobe(1); irq_clr = 0; idle(1);
        chk("R6 set beats clear", irq, 1'b0);
        uv_raw[0] = 0; strobe(3);
        irq_clr = 1; @(negedge clk); irq_clr = 0; idle(4);

        // R1: need 0 behaves as 1
        need = '0; uv_raw[1] = 1; strobe(1);
        chk("R1 need zero qualifies in one", healthy, 1'b0);
        uv_raw[1] = 0; strobe(1); idle(4);
        chk("R1 need zero clears in one", healthy, 1'b1);
        need = 4'd3;

        // R7: inverted polarities
        p_hlt = 0; p_irq = 1; p_rst = 1; idle(1);
        chk("R7 healthy active-low",  healthy, 1'b0);
        chk("R7 irq inactive low",    irq,     1'b0);
        chk("R7 rst inactive low",    rst,     1'b0);
        uv_raw[0] = 1; strobe(3);
        chk("R7 irq active high",     irq,     1'b1);
        chk("R7 rst active high",     rst,     1'b1);
        chk("R7 healthy fault high",  healthy, 1'b1);
        uv_raw[0] = 0; strobe(3); idle(4);

        cmp_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule